// File: doc/BRIEF.md
# Data Space Address Generation Unit

This block computes the data-space address for each load or store. The address comes either from an immediate direct address or from one of three 16-bit pointers, X, Y and Z. Each pointer is an alias for a pair of general registers, R26 to R31. The unit supports these forms of pointer access:

- plain indirect;
- indirect with an unsigned 6-bit displacement, on Y and Z only;
- indirect with pre-decrement;
- indirect with post-increment.

For the two auto-modify modes it also produces the updated pointer value and the register index where it must be written back.

Each computed address is decoded into the combined data space:

| Region | Addresses |
|---|---|
| General register file | lowest 32 locations |
| I/O registers | next 64 locations |
| Internal SRAM | next 1024 locations |

The unit returns a one-hot region select and the offset local to that region. An address at or above 1120 is flagged as out of range, and its access strobe is withheld. All results are registered and appear one cycle after the request strobe. The register storage and the SRAM array sit outside the block. The current pointer bytes are fed in, and the write-back outputs are consumed by the register file.

Top module: `dspace_agu`

## Requirements
- R1: Mode codes on `mode_i`: 0 = direct, 1 = indirect, 2 = indirect with displacement, 3 = pre-decrement, 4 = post-increment. In mode 0 the address equals `direct_addr_i`. In mode 1 the address equals the selected pointer.
- R2: Byte k of `ptr_bytes_i` (bits 8k+7:8k) carries register R(26+k). Each pointer has its low byte in the even register and its high byte in the odd register (X = {R27,R26}, Y = {R29,R28}, Z = {R31,R30}). `ptr_sel_i` selects 0 = X, 1 = Y, 2 = Z, and 3 also selects Z.
- R3: In mode 2 with Y or Z selected, the address is the pointer plus the zero-extended `disp_i` (0 to 63). With X selected, the displacement is ignored and the address is the pointer itself.
- R4: In mode 3 the address is the pointer minus one. The write-back value is that same decremented pointer.
- R5: In mode 4 the address is the unmodified pointer and the write-back value is the pointer plus one. `wb_en_o` is asserted only for modes 3 and 4. `wb_idx_o` then gives the low register of the selected pair: 26, 28 or 30.
- R6: All pointer and displacement arithmetic wraps modulo 2^16.
- R7: `region_o` is one-hot:
  - bit 0: register file, addresses 0–31, offset = address;
  - bit 1: I/O, addresses 32–95, offset = address − 32;
  - bit 2: SRAM, addresses 96–1119, offset = address − 96.
- R8: An address of 1120 or more sets `oor_o`, clears `region_o` and `offset_o`, and holds `strobe_o` low. Write-back still occurs for modes 3 and 4.
- R9: `valid_o` is high for exactly the one cycle after each cycle in which `req_i` is high. `strobe_o` and `wb_en_o` are high only while `valid_o` is.
- R10: Mode codes 5 to 7 produce `valid_o` with address 0, no region, offset 0, no out-of-range flag, no strobe and no write-back.
- R11: While reset is asserted and after its release, `valid_o`, `strobe_o`, `wb_en_o` and `oor_o` are low until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; operands are sampled in this cycle |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select |
| disp_i | input | 6 | Unsigned displacement |
| direct_addr_i | input | 16 | Direct address |
| ptr_bytes_i | input | 48 | Current contents of R26..R31, R26 in the lowest byte |
| valid_o | output | 1 | Results valid this cycle |
| strobe_o | output | 1 | Access strobe; in range and legal mode |
| addr_o | output | 16 | Computed effective address |
| region_o | output | 3 | One-hot region: bit 0 register file, bit 1 I/O, bit 2 SRAM |
| offset_o | output | 10 | Offset within the selected region |
| oor_o | output | 1 | Out-of-range flag |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_idx_o | output | 5 | Register index of the low byte to write back |
| wb_value_o | output | 16 | Updated pointer value |

## Verification
A wrong pointer selection or a byte swap inside a pair shows at `addr_o` and `region_o` in the cycle right after the request. A mistaken region boundary moves `region_o` and `offset_o` at the 31/32, 95/96 and 1119/1120 edges. An error in the modify arithmetic shows in `wb_value_o` in that same cycle, or as a missing or spurious `wb_en_o`. Because every output is registered once from the request, every fault is visible at the ports within one cycle of the request that provokes it. The bench also drives wrap-around cases at 0x0000 and 0xFFFF.

// File: rtl/dspace_agu_pkg.sv
package dspace_agu_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } amode_e;

  localparam int unsigned REG_IDX_W = 5;

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int unsigned NPTR     = 3,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_REG = 26,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [NPTR*ADDR_W-1:0] bytes_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [ADDR_W-1:0]      ptr_o,
  output logic [IDX_W-1:0]       lo_idx_o,
  output logic                   is_first_o
);
  localparam int unsigned BYTE_W = ADDR_W / 2;

  logic [ADDR_W-1:0] ptr_arr [NPTR];
  logic [SEL_W-1:0]  idx;

  for (genvar p = 0; p < NPTR; p++) begin : g_pair
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    assign lo_byte    = bytes_i[(2*p)*BYTE_W   +: BYTE_W];
    assign hi_byte    = bytes_i[(2*p+1)*BYTE_W +: BYTE_W];
    assign ptr_arr[p] = {hi_byte, lo_byte};
  end

  always_comb begin
    if (int'(sel_i) >= NPTR) idx = SEL_W'(NPTR - 1);
    else                     idx = sel_i;
    ptr_o      = ptr_arr[idx];
    lo_idx_o   = IDX_W'(BASE_REG + 2 * int'(idx));
    is_first_o = (idx == '0);
  end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import dspace_agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 6
) (
  input  logic [2:0]        mode_i,
  input  logic              no_disp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] direct_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] new_ptr_o,
  output logic              wb_en_o,
  output logic              legal_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_dec;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_disp;

  assign ptr_dec  = ptr_i - ONE;
  assign ptr_inc  = ptr_i + ONE;
  assign ptr_disp = ptr_i + {{(ADDR_W-DISP_W){1'b0}}, disp_i};

  always_comb begin
    ea_o      = '0;
    new_ptr_o = ptr_i;
    wb_en_o   = 1'b0;
    legal_o   = 1'b1;
    case (mode_i)
      AM_DIRECT:  ea_o = direct_i;
      AM_IND:     ea_o = ptr_i;
      AM_DISP:    ea_o = no_disp_i ? ptr_i : ptr_disp;
      AM_PREDEC: begin
        ea_o      = ptr_dec;
        new_ptr_o = ptr_dec;
        wb_en_o   = 1'b1;
      end
      AM_POSTINC: begin
        ea_o      = ptr_i;
        new_ptr_o = ptr_inc;
        wb_en_o   = 1'b1;
      end
      default:    legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/agu_region_dec.sv
module agu_region_dec #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned RF_DEPTH   = 32,
  parameter int unsigned IO_DEPTH   = 64,
  parameter int unsigned SRAM_DEPTH = 1024,
  parameter int unsigned OFF_W      = 10,
  parameter int unsigned NREG       = 3
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              legal_i,
  output logic [NREG-1:0]   region_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              oor_o
);
  localparam logic [ADDR_W-1:0] BASE_IO   = ADDR_W'(RF_DEPTH);
  localparam logic [ADDR_W-1:0] BASE_SRAM = ADDR_W'(RF_DEPTH + IO_DEPTH);
  localparam logic [ADDR_W-1:0] TOP_ALL   = ADDR_W'(RF_DEPTH + IO_DEPTH + SRAM_DEPTH);

  logic [ADDR_W-1:0] rel_io;
  logic [ADDR_W-1:0] rel_sram;

  assign rel_io   = ea_i - BASE_IO;
  assign rel_sram = ea_i - BASE_SRAM;

  always_comb begin
    region_o = '0;
    offset_o = '0;
    oor_o    = 1'b0;
    if (legal_i) begin
      if (ea_i < BASE_IO) begin
        region_o[0] = 1'b1;
        offset_o    = OFF_W'(ea_i);
      end else if (ea_i < BASE_SRAM) begin
        region_o[1] = 1'b1;
        offset_o    = OFF_W'(rel_io);
      end else if (ea_i < TOP_ALL) begin
        region_o[2] = 1'b1;
        offset_o    = OFF_W'(rel_sram);
      end else begin
        oor_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import dspace_agu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DISP_W     = 6,
  parameter int unsigned NPTR       = 3,
  parameter int unsigned BASE_REG   = 26,
  parameter int unsigned RF_DEPTH   = 32,
  parameter int unsigned IO_DEPTH   = 64,
  parameter int unsigned SRAM_DEPTH = 1024,
  parameter int unsigned OFF_W      = $clog2(SRAM_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic [2:0]              mode_i,
  input  logic [1:0]              ptr_sel_i,
  input  logic [DISP_W-1:0]       disp_i,
  input  logic [ADDR_W-1:0]       direct_addr_i,
  input  logic [NPTR*ADDR_W-1:0]  ptr_bytes_i,
  output logic                    valid_o,
  output logic                    strobe_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [2:0]              region_o,
  output logic [OFF_W-1:0]        offset_o,
  output logic                    oor_o,
  output logic                    wb_en_o,
  output logic [REG_IDX_W-1:0]    wb_idx_o,
  output logic [ADDR_W-1:0]       wb_value_o
);
  localparam logic [ADDR_W-1:0] BASE_SRAM = ADDR_W'(RF_DEPTH + IO_DEPTH);
  localparam logic [ADDR_W-1:0] TOP_ALL   = ADDR_W'(RF_DEPTH + IO_DEPTH + SRAM_DEPTH);

  logic [ADDR_W-1:0]    ptr;
  logic [REG_IDX_W-1:0] lo_idx;
  logic                 is_x;
  logic [ADDR_W-1:0]    ea;
  logic [ADDR_W-1:0]    new_ptr;
  logic                 wb_en_c;
  logic                 legal;
  logic [2:0]           region_c;
  logic [OFF_W-1:0]     offset_c;
  logic                 oor_c;

  agu_ptr_mux #(
    .NPTR(NPTR), .ADDR_W(ADDR_W), .BASE_REG(BASE_REG), .SEL_W(2), .IDX_W(REG_IDX_W)
  ) u_ptr_mux (
    .bytes_i(ptr_bytes_i), .sel_i(ptr_sel_i), .ptr_o(ptr),
    .lo_idx_o(lo_idx), .is_first_o(is_x)
  );

  agu_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr_calc (
    .mode_i(mode_i), .no_disp_i(is_x), .ptr_i(ptr), .disp_i(disp_i),
    .direct_i(direct_addr_i), .ea_o(ea), .new_ptr_o(new_ptr),
    .wb_en_o(wb_en_c), .legal_o(legal)
  );

  agu_region_dec #(
    .ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH), .IO_DEPTH(IO_DEPTH),
    .SRAM_DEPTH(SRAM_DEPTH), .OFF_W(OFF_W), .NREG(3)
  ) u_region_dec (
    .ea_i(ea), .legal_i(legal), .region_o(region_c),
    .offset_o(offset_c), .oor_o(oor_c)
  );

  // next-state for the qualifier flops
  logic valid_d, strobe_d, wb_en_d;
  always_comb begin
    valid_d  = req_i;
    strobe_d = req_i & legal & ~oor_c;
    wb_en_d  = req_i & wb_en_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      strobe_o <= 1'b0;
      wb_en_o  <= 1'b0;
    end else begin
      valid_o  <= valid_d;
      strobe_o <= strobe_d;
      wb_en_o  <= wb_en_d;
    end
  end

  // data flops, loaded only on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o     <= '0;
      region_o   <= '0;
      offset_o   <= '0;
      oor_o      <= 1'b0;
      wb_idx_o   <= '0;
      wb_value_o <= '0;
    end else if (req_i) begin
      addr_o     <= ea;
      region_o   <= region_c;
      offset_o   <= offset_c;
      oor_o      <= oor_c;
      wb_idx_o   <= lo_idx;
      wb_value_o <= new_ptr;
    end
  end

  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);
  a_r9_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o || wb_en_o) |-> valid_o);
  a_r7_region_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_o));
  a_r7_sram_window: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && region_o[2]) |-> (addr_o >= BASE_SRAM && addr_o < TOP_ALL));
  a_r8_oor_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && oor_o) |-> (!strobe_o && region_o == 3'b000 && addr_o >= TOP_ALL));
  a_r5_postinc_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == AM_POSTINC) |=> (wb_en_o && wb_value_o == addr_o + ADDR_W'(1)));
  a_r4_predec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == AM_PREDEC) |=> (wb_en_o && wb_value_o == addr_o));
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i > 3'd4) |=> (!strobe_o && !wb_en_o && !oor_o && region_o == 3'b000));

endmodule

// File: tb/dspace_agu_tb.sv
module dspace_agu_tb;
  localparam time TCLK = 10ns;
  localparam int  NVEC = 20;

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  sel;
    logic [5:0]  disp;
    logic [15:0] dir;
    logic [15:0] ea;
    logic [2:0]  rgn;
    logic [9:0]  off;
    logic        oor;
    logic        stb;
    logic        wbe;
    logic [4:0]  wbi;
    logic [15:0] wbv;
  } vec_t;

  // pointers for the table: X=0x001F, Y=0x005F, Z=0x045F
  localparam vec_t TBL [NVEC] = '{
    '{3'd0, 2'd0, 6'd0,  16'h0000, 16'h0000, 3'b001, 10'd0,    1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R1 R7 rf low
    '{3'd0, 2'd0, 6'd0,  16'h001F, 16'h001F, 3'b001, 10'd31,   1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R7 rf top
    '{3'd0, 2'd0, 6'd0,  16'h0020, 16'h0020, 3'b010, 10'd0,    1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R7 io low
    '{3'd0, 2'd0, 6'd0,  16'h005F, 16'h005F, 3'b010, 10'd63,   1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R7 io top
    '{3'd0, 2'd0, 6'd0,  16'h0060, 16'h0060, 3'b100, 10'd0,    1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R7 sram low
    '{3'd0, 2'd0, 6'd0,  16'h045F, 16'h045F, 3'b100, 10'd1023, 1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R7 sram top
    '{3'd0, 2'd0, 6'd0,  16'h0460, 16'h0460, 3'b000, 10'd0,    1'b1, 1'b0, 1'b0, 5'd0,  16'h0}, // R8 first oor
    '{3'd0, 2'd0, 6'd0,  16'hFFFF, 16'hFFFF, 3'b000, 10'd0,    1'b1, 1'b0, 1'b0, 5'd0,  16'h0}, // R8 top
    '{3'd1, 2'd0, 6'd9,  16'h1234, 16'h001F, 3'b001, 10'd31,   1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R1 R2 X
    '{3'd1, 2'd1, 6'd0,  16'h0000, 16'h005F, 3'b010, 10'd63,   1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R2 Y
    '{3'd1, 2'd3, 6'd0,  16'h0000, 16'h045F, 3'b100, 10'd1023, 1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R2 sel3 -> Z
    '{3'd2, 2'd1, 6'd1,  16'h0000, 16'h0060, 3'b100, 10'd0,    1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R3 Y+1
    '{3'd2, 2'd2, 6'd0,  16'h0000, 16'h045F, 3'b100, 10'd1023, 1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R3 Z+0
    '{3'd2, 2'd2, 6'd63, 16'h0000, 16'h049E, 3'b000, 10'd0,    1'b1, 1'b0, 1'b0, 5'd0,  16'h0}, // R3 R8 Z+63
    '{3'd2, 2'd0, 6'd5,  16'h0000, 16'h001F, 3'b001, 10'd31,   1'b0, 1'b1, 1'b0, 5'd0,  16'h0}, // R3 X ignores disp
    '{3'd3, 2'd0, 6'd0,  16'h0000, 16'h001E, 3'b001, 10'd30,   1'b0, 1'b1, 1'b1, 5'd26, 16'h001E}, // R4 X
    '{3'd3, 2'd1, 6'd0,  16'h0000, 16'h005E, 3'b010, 10'd62,   1'b0, 1'b1, 1'b1, 5'd28, 16'h005E}, // R4 Y
    '{3'd4, 2'd1, 6'd0,  16'h0000, 16'h005F, 3'b010, 10'd63,   1'b0, 1'b1, 1'b1, 5'd28, 16'h0060}, // R5 Y
    '{3'd4, 2'd2, 6'd0,  16'h0000, 16'h045F, 3'b100, 10'd1023, 1'b0, 1'b1, 1'b1, 5'd30, 16'h0460}, // R5 Z
    '{3'd6, 2'd1, 6'd3,  16'h0040, 16'h0000, 3'b000, 10'd0,    1'b0, 1'b0, 1'b0, 5'd0,  16'h0}  // R10 illegal
  };

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  mode_i;
  logic [1:0]  ptr_sel_i;
  logic [5:0]  disp_i;
  logic [15:0] direct_addr_i;
  logic [47:0] ptr_bytes_i;
  logic        valid_o, strobe_o, oor_o, wb_en_o;
  logic [15:0] addr_o, wb_value_o;
  logic [2:0]  region_o;
  logic [9:0]  offset_o;
  logic [4:0]  wb_idx_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  dspace_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .disp_i(disp_i), .direct_addr_i(direct_addr_i),
    .ptr_bytes_i(ptr_bytes_i), .valid_o(valid_o), .strobe_o(strobe_o),
    .addr_o(addr_o), .region_o(region_o), .offset_o(offset_o), .oor_o(oor_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_value_o(wb_value_o)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one request, then compare outputs one cycle later
  task automatic run_vec(input string tag, input vec_t v);
    logic [68:0] act, exp;
    @(negedge clk);
    req_i = 1'b1; mode_i = v.mode; ptr_sel_i = v.sel;
    disp_i = v.disp; direct_addr_i = v.dir;
    @(negedge clk);
    req_i = 1'b0;
    act = {valid_o, addr_o, region_o, offset_o, oor_o, strobe_o, wb_en_o,
           (wb_en_o ? wb_idx_o : 5'd0), (wb_en_o ? wb_value_o : 16'h0)};
    exp = {1'b1, v.ea, v.rgn, v.off, v.oor, v.stb, v.wbe,
           (v.wbe ? v.wbi : 5'd0), (v.wbe ? v.wbv : 16'h0)};
    chk(tag, 64'(act), 64'(exp));
    if (act[68:64] !== exp[68:64]) begin
      errors++;
      $display("FAIL %s upper fields actual=%h expected=%h", tag, act[68:64], exp[68:64]);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; mode_i = '0; ptr_sel_i = '0;
    disp_i = '0; direct_addr_i = '0;
    ptr_bytes_i = {16'h045F, 16'h005F, 16'h001F};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset", 64'({valid_o, strobe_o, wb_en_o, oor_o}), 64'(4'b0000));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release", 64'({valid_o, strobe_o, wb_en_o, oor_o}), 64'(4'b0000));

    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = $sformatf("table[%0d] R1..R10", i);
      run_vec(t, TBL[i]);
    end

    // R9: no request -> valid drops after one cycle
    @(negedge clk);
    chk("R9 valid single cycle", 64'({valid_o, strobe_o, wb_en_o}), 64'(3'b000));

    // R2 byte order: X={R27,R26}=0x0102 -> io? 0x0102 = 258 -> sram offset 162
    ptr_bytes_i = {16'h045F, 16'h005F, 8'h01, 8'h02};
    run_vec("R2 byte order", '{3'd1, 2'd0, 6'd0, 16'h0, 16'h0102, 3'b100, 10'd162,
                               1'b0, 1'b1, 1'b0, 5'd0, 16'h0});

    // R6 wrap: X=0x0000 predec -> 0xFFFF oor, writeback 0xFFFF (R8 still writes back)
    ptr_bytes_i = {16'hFFF0, 16'hFFFF, 16'h0000};
    run_vec("R6 R8 predec wrap", '{3'd3, 2'd0, 6'd0, 16'h0, 16'hFFFF, 3'b000, 10'd0,
                                   1'b1, 1'b0, 1'b1, 5'd26, 16'hFFFF});
    // R6 wrap: Y=0xFFFF postinc -> writeback 0x0000
    run_vec("R6 postinc wrap", '{3'd4, 2'd1, 6'd0, 16'h0, 16'hFFFF, 3'b000, 10'd0,
                                 1'b1, 1'b0, 1'b1, 5'd28, 16'h0000});
    // R6 wrap: Z=0xFFF0 + 32 -> 0x0010 register file
    run_vec("R6 disp wrap", '{3'd2, 2'd2, 6'd32, 16'h0, 16'h0010, 3'b001, 10'd16,
                              1'b0, 1'b1, 1'b0, 5'd0, 16'h0});

    // R9 back-to-back requests keep valid high each cycle
    @(negedge clk);
    req_i = 1'b1; mode_i = 3'd0; direct_addr_i = 16'h0021;
    @(negedge clk);
    direct_addr_i = 16'h0070;
    chk("R9 b2b first", 64'({valid_o, addr_o, region_o}), 64'({1'b1, 16'h0021, 3'b010}));
    @(negedge clk);
    req_i = 1'b0;
    chk("R9 b2b second", 64'({valid_o, addr_o, region_o, offset_o}),
        64'({1'b1, 16'h0070, 3'b100, 10'd16}));
    @(negedge clk);
    chk("R9 idle", 64'(valid_o), 64'(1'b0));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule